// File: doc/BRIEF.md
# UART Receive Holding Buffer

This block holds characters that a UART receive shift register has assembled until the host reads them. Each character arrives in parallel form with three error flags: parity error, framing error and break. The flags are stored in the same entry as the character, and both come out together at the read side. The host sees the oldest held entry, a fill count, a data-ready level and a sticky overrun flag.

Two storage modes are selected by `fifo_en`:

- **Queue mode** keeps up to `DEPTH` entries (64 by default) in arrival order. A character that arrives while the queue is full is discarded.
- **Single-slot mode** uses only storage location 0. A character that arrives while the slot is occupied replaces the held one.

Either kind of loss raises the overrun flag, which the host clears by a line-status read. The word length of the incoming character (5 to 8 bits) is given with each write. Bits above the word length are stored as zero.

Top module: `uart_rx_hold_buf`

## Requirements
- R1: In queue mode, characters are read in arrival order. The head outputs show the oldest entry's data and its own perr/ferr/brk bits, and `rd_pop` removes that entry at the clock edge.
- R2: `wr_len` selects the word length as 5 + `wr_len` bits (0 = 5 bits up to 3 = 8 bits). Stored data bits at and above the word length are zero.
- R3: `fill_count` reports occupancy from 0 to `DEPTH`, and `data_ready` is high exactly when `fill_count` is non-zero. While the buffer is empty, all head outputs are zero.
- R4: In queue mode with `DEPTH` entries held, a write without a pop is discarded. The count and stored contents are unchanged, and `overrun` is set.
- R5: In queue mode with `DEPTH` entries held, a write and a pop in the same cycle are both accepted. The count stays at `DEPTH`, the new character joins the tail, and `overrun` is not set.
- R6: In single-slot mode, `fill_count` never exceeds 1. A write while a character is held replaces it with the new one and sets `overrun`.
- R7: In single-slot mode, a write and a pop in the same cycle while a character is held leave the new character held, with no overrun.
- R8: `overrun` is sticky and clears on `lsr_rd`. When a loss occurs in the same cycle as `lsr_rd`, the flag ends set.
- R9: When `fifo_en` differs from the mode value registered in the previous cycle, the buffer empties at that edge. Any write or pop in that cycle is ignored, and `overrun` keeps its value.
- R10: After reset the buffer is empty, `overrun` is clear, and the registered mode is 0 (single slot).
- R11: A pop while the buffer is empty has no effect on the count or the contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single-slot mode |
| wr_valid | input | 1 | A character from the shift register is present this cycle |
| wr_data | input | 8 | Received character, right-aligned |
| wr_len | input | 2 | Word length code: 5 + value bits |
| wr_perr | input | 1 | Parity error flag of this character |
| wr_ferr | input | 1 | Framing error flag of this character |
| wr_brk | input | 1 | Break flag of this character |
| rd_pop | input | 1 | Host read: removes the head entry |
| lsr_rd | input | 1 | Host line-status read: clears overrun |
| head_data | output | 8 | Data of the oldest entry |
| head_perr | output | 1 | Parity error of the oldest entry |
| head_ferr | output | 1 | Framing error of the oldest entry |
| head_brk | output | 1 | Break flag of the oldest entry |
| data_ready | output | 1 | At least one entry is held |
| fill_count | output | 7 | Number of entries held |
| overrun | output | 1 | Sticky lost-or-overwritten indication |

## Verification
A write and a pop can fall in the same cycle, and the outcome depends on occupancy and mode. The bench drives both together into a full queue, where neither may be lost. It also drives both together into an occupied single slot, where the new character must end up held without an overrun. A reference queue in the bench, updated pop-first then push, predicts the count, the head entry and the overrun flag after each such cycle. A loss coinciding with a line-status read is also provoked, to judge which of the two wins on the flag.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;

   localparam int unsigned CHAR_W = 8;

   typedef struct packed {
      logic              brk;
      logic              ferr;
      logic              perr;
      logic [CHAR_W-1:0] data;
   } rx_entry_t;

   localparam int unsigned ENTRY_W = $bits(rx_entry_t);

endpackage

// File: rtl/rxbuf_len_mask.sv
module rxbuf_len_mask #(
   parameter int unsigned CHAR_W   = 8,
   parameter int unsigned LEN_W    = 2,
   parameter int unsigned MIN_BITS = 5
) (
   input  logic [CHAR_W-1:0] din,
   input  logic [LEN_W-1:0]  len_code,
   output logic [CHAR_W-1:0] dout
);

   if (MIN_BITS + (1 << LEN_W) - 1 != CHAR_W) begin : g_bad_len
      $error("rxbuf_len_mask: length code range does not reach CHAR_W");
   end

   for (genvar i = 0; i < CHAR_W; i++) begin : g_bit
      if (i < MIN_BITS) begin : g_always
         assign dout[i] = din[i];
      end else begin : g_gated
         // Bit i is valid when the word holds more than i bits. R2
         assign dout[i] = din[i] & (len_code >= LEN_W'(i - MIN_BITS + 1));
      end
   end

endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned WIDTH = 11,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_en,
   input  logic          wr_valid,
   input  logic          rd_pop,
   output logic          mem_we,
   output logic [AW-1:0] mem_waddr,
   output logic [AW-1:0] mem_raddr,
   output logic [CW-1:0] count,
   output logic          lost
);

   logic          mode_q;
   logic          flush;
   logic [AW-1:0] wptr_q, rptr_q;
   logic [CW-1:0] cap;
   logic          empty, room, do_pop, do_wr, overwrite, drop;

   assign flush     = (fifo_en != mode_q);
   assign empty     = (count == '0);
   assign cap       = mode_q ? CW'(DEPTH) : CW'(1);
   assign do_pop    = rd_pop && !empty && !flush;
   assign room      = (count < cap) || do_pop;
   assign do_wr     = wr_valid && !flush && room;
   assign overwrite = wr_valid && !flush && !room && !mode_q;
   assign drop      = wr_valid && !flush && !room && mode_q;
   assign lost      = overwrite || drop;

   assign mem_we    = do_wr || overwrite;
   assign mem_waddr = mode_q ? wptr_q : '0;
   assign mem_raddr = mode_q ? rptr_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         wptr_q <= '0;
         rptr_q <= '0;
         count  <= '0;
      end else begin
         mode_q <= fifo_en;
         if (flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            count  <= '0;
         end else begin
            if (mode_q && do_wr)  wptr_q <= wptr_q + AW'(1);
            if (mode_q && do_pop) rptr_q <= rptr_q + AW'(1);
            count <= count + CW'(do_wr) - CW'(do_pop);
         end
      end
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));                                           // R3
   AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> count <= CW'(1));                                   // R6
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && fifo_en && count == CW'(DEPTH) && wr_valid && !rd_pop)
      |=> count == CW'(DEPTH));                                       // R4
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en != mode_q) |=> count == '0);                           // R9
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en == mode_q && count == '0 && rd_pop && !wr_valid)
      |=> count == '0);                                               // R11
   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en == mode_q && count != '0 && rd_pop && !wr_valid)
      |=> count == $past(count) - CW'(1));                            // R1

endmodule

// File: rtl/rxbuf_overrun.sv
module rxbuf_overrun (
   input  logic clk,
   input  logic rst_n,
   input  logic lost,
   input  logic lsr_rd,
   output logic ovr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ovr <= 1'b0;
      else if (lost)   ovr <= 1'b1;
      else if (lsr_rd) ovr <= 1'b0;
   end

   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      lost |=> ovr);                                                  // R8
   AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !lost) |=> !ovr);                                    // R8
   AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!lsr_rd && !lost) |=> $stable(ovr));                           // R8

endmodule

// File: rtl/uart_rx_hold_buf.sv
module uart_rx_hold_buf
   import uart_rxbuf_pkg::*;
#(
   parameter int unsigned DEPTH    = 64,
   parameter int unsigned LEN_W    = 2,
   parameter int unsigned MIN_BITS = 5,
   localparam int unsigned AW      = $clog2(DEPTH),
   localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              wr_valid,
   input  logic [CHAR_W-1:0] wr_data,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic              wr_perr,
   input  logic              wr_ferr,
   input  logic              wr_brk,
   input  logic              rd_pop,
   input  logic              lsr_rd,
   output logic [CHAR_W-1:0] head_data,
   output logic              head_perr,
   output logic              head_ferr,
   output logic              head_brk,
   output logic              data_ready,
   output logic [CW-1:0]     fill_count,
   output logic              overrun
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_rx_hold_buf: DEPTH must be a power of two, at least 2");
   end

   logic [CHAR_W-1:0] masked;
   rx_entry_t         wr_entry, rd_entry;
   logic [ENTRY_W-1:0] rd_raw;
   logic              mem_we, lost;
   logic [AW-1:0]     mem_waddr, mem_raddr;

   rxbuf_len_mask #(.CHAR_W(CHAR_W), .LEN_W(LEN_W), .MIN_BITS(MIN_BITS)) u_mask (
      .din(wr_data), .len_code(wr_len), .dout(masked)
   );

   assign wr_entry = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr, data: masked};

   rxbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .wr_valid(wr_valid),
      .rd_pop(rd_pop), .mem_we(mem_we), .mem_waddr(mem_waddr),
      .mem_raddr(mem_raddr), .count(fill_count), .lost(lost)
   );

   rxbuf_store #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_store (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_entry),
      .raddr(mem_raddr), .rdata(rd_raw)
   );

   rxbuf_overrun u_ovr (
      .clk(clk), .rst_n(rst_n), .lost(lost), .lsr_rd(lsr_rd), .ovr(overrun)
   );

   assign data_ready = (fill_count != '0);
   assign rd_entry   = data_ready ? rx_entry_t'(rd_raw) : '0;
   assign head_data  = rd_entry.data;
   assign head_perr  = rd_entry.perr;
   assign head_ferr  = rd_entry.ferr;
   assign head_brk   = rd_entry.brk;

   AST_READY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !data_ready |-> (head_data == '0 && !head_perr && !head_ferr && !head_brk)); // R3

endmodule

// File: tb/uart_rx_hold_buf_tb.sv
`timescale 1ns/1ps
module uart_rx_hold_buf_tb;

   localparam int DEPTH = 64;

   logic       clk = 0, rst_n = 0;
   logic       fifo_en = 0, wr_valid = 0, wr_perr = 0, wr_ferr = 0, wr_brk = 0;
   logic       rd_pop = 0, lsr_rd = 0;
   logic [7:0] wr_data = 0;
   logic [1:0] wr_len = 0;
   logic [7:0] head_data;
   logic       head_perr, head_ferr, head_brk, data_ready, overrun;
   logic [6:0] fill_count;

   int checks = 0, errors = 0;
   logic [10:0] q[$];
   bit en_prev = 0;
   bit ovr_m = 0;

   always #2.5 clk = ~clk;

   uart_rx_hold_buf u_dut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_len(wr_len), .wr_perr(wr_perr), .wr_ferr(wr_ferr),
      .wr_brk(wr_brk), .rd_pop(rd_pop), .lsr_rd(lsr_rd), .head_data(head_data),
      .head_perr(head_perr), .head_ferr(head_ferr), .head_brk(head_brk),
      .data_ready(data_ready), .fill_count(fill_count), .overrun(overrun)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Monitor side: compare what the head shows against the scoreboard front.
   task automatic check_head(input string tag);
      logic [10:0] act;
      act = {head_brk, head_ferr, head_perr, head_data};
      if (q.size() > 0) chk("R1", {tag, " head entry"}, int'(act), int'(q[0]));
      else              chk("R3", {tag, " empty head"}, int'(act), 0);
   endtask

   // Driver side: one clock with the given stimulus; the scoreboard is updated pop first, then push.
   task automatic cycle(input bit en, input bit wr, input logic [7:0] d, input logic [1:0] ln,
                        input bit p, input bit f, input bit b, input bit pop, input bit lsr,
                        input string tag);
      bit lost;
      int cap;
      logic [7:0] md;
      check_head(tag);
      fifo_en = en; wr_valid = wr; wr_data = d; wr_len = ln;
      wr_perr = p; wr_ferr = f; wr_brk = b; rd_pop = pop; lsr_rd = lsr;
      lost = 0;
      md = d & 8'((1 << (5 + int'(ln))) - 1);
      if (en != en_prev) q.delete();
      else begin
         cap = en ? DEPTH : 1;
         if (pop && q.size() > 0) void'(q.pop_front());
         if (wr) begin
            if (q.size() < cap) q.push_back({b, f, p, md});
            else begin
               lost = 1;
               if (!en) q[0] = {b, f, p, md};
            end
         end
      end
      en_prev = en;
      ovr_m = lost ? 1'b1 : (lsr ? 1'b0 : ovr_m);
      @(posedge clk); @(negedge clk);
      wr_valid = 0; rd_pop = 0; lsr_rd = 0;
      chk(tag, "fill_count", int'(fill_count), q.size());
      chk("R3", {tag, " data_ready"}, int'(data_ready), int'(q.size() != 0));
      chk("R8", {tag, " overrun"}, int'(overrun), int'(ovr_m));
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10", "reset count", int'(fill_count), 0);
      chk("R10", "reset overrun", int'(overrun), 0);
      chk("R10", "reset ready", int'(data_ready), 0);
      rst_n = 1;
      @(negedge clk);

      // Enter queue mode: this cycle flushes, so the write must vanish.
      cycle(1, 1, 8'h77, 2'd3, 0, 0, 0, 0, 0, "R9");
      // Word lengths and per-character flags.
      cycle(1, 1, 8'hFF, 2'd0, 1, 0, 0, 0, 0, "R2");
      cycle(1, 1, 8'hFF, 2'd1, 0, 1, 0, 0, 0, "R2");
      cycle(1, 1, 8'hFF, 2'd2, 0, 0, 1, 0, 0, "R2");
      cycle(1, 1, 8'hC3, 2'd3, 1, 1, 1, 0, 0, "R2");
      for (int i = 0; i < 4; i++) cycle(1, 0, 0, 0, 0, 0, 0, 1, 0, "R1");
      cycle(1, 0, 0, 0, 0, 0, 0, 1, 0, "R11");

      // Fill to capacity.
      for (int i = 0; i < DEPTH; i++)
         cycle(1, 1, 8'(i) ^ 8'hA5, 2'd3, i[0], i[1], i[2], 0, 0, "R3");
      cycle(1, 1, 8'h11, 2'd3, 1, 1, 1, 0, 0, "R4");
      cycle(1, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
      cycle(1, 1, 8'h5A, 2'd3, 0, 1, 0, 1, 0, "R5");
      cycle(1, 1, 8'h22, 2'd3, 0, 0, 0, 0, 1, "R8");
      cycle(1, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
      for (int i = 0; i < DEPTH; i++) cycle(1, 0, 0, 0, 0, 0, 0, 1, 0, "R1");
      cycle(1, 0, 0, 0, 0, 0, 0, 1, 0, "R11");

      // Partial fill, then mode switch with a write in the same cycle.
      cycle(1, 1, 8'h31, 2'd3, 0, 0, 0, 0, 0, "R1");
      cycle(1, 1, 8'h32, 2'd3, 0, 0, 0, 0, 0, "R1");
      cycle(0, 1, 8'h33, 2'd3, 0, 0, 0, 0, 0, "R9");

      // Single-slot mode.
      cycle(0, 1, 8'h41, 2'd3, 1, 0, 0, 0, 0, "R6");
      cycle(0, 1, 8'h42, 2'd3, 0, 1, 0, 0, 0, "R6");
      cycle(0, 1, 8'h43, 2'd1, 0, 0, 1, 0, 0, "R6");
      cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
      cycle(0, 1, 8'h44, 2'd3, 1, 1, 0, 1, 0, "R7");
      cycle(0, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
      cycle(0, 0, 0, 0, 0, 0, 0, 1, 0, "R11");

      // Flush while occupied keeps overrun; switch back to queue mode.
      cycle(0, 1, 8'h51, 2'd3, 0, 0, 0, 0, 0, "R6");
      cycle(0, 1, 8'h52, 2'd3, 0, 0, 0, 0, 0, "R6");
      cycle(1, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
      cycle(1, 1, 8'h61, 2'd3, 0, 0, 0, 0, 1, "R1");
      cycle(1, 0, 0, 0, 0, 0, 0, 1, 0, "R1");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule